// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits inside a small processor core. It owns the short, fixed sequences the core runs when it enters an interrupt handler and when it leaves one. At an instruction boundary with the global interrupt enable set and at least one request pending, it takes the lowest-numbered pending source. It then runs four cycles in which the core's fetch is stalled. In those cycles it acknowledges the source, clears the global enable, writes the two-byte return address into a byte-wide stack memory, moves the stack pointer down by two and loads the program counter with that source's vector.

When the core reports that the instruction ending at a boundary is a return-from-interrupt, the block runs four cycles of its own. It reads the two bytes back, moves the stack pointer up by two, reloads the program counter and sets the global enable. Afterwards it lets exactly one main-program instruction complete before it will accept another request.

States: `S_IDLE`, `S_PUSH_LO`, `S_PUSH_HI`, `S_ENT_SP`, `S_ENT_VEC`, `S_POP_HI`, `S_POP_LO`, `S_RET_SP`, `S_RET_PC`, `S_GUARD`. Transitions:
- take: `S_IDLE` to `S_PUSH_LO` at a boundary.
- entry chain: `S_PUSH_LO`, then `S_PUSH_HI`, then `S_ENT_SP`, then `S_ENT_VEC`, then back to `S_IDLE`.
- return: `S_IDLE` or `S_GUARD` to `S_POP_HI` at a boundary with a return.
- return chain: `S_POP_HI`, then `S_POP_LO`, then `S_RET_SP`, then `S_RET_PC`, then `S_GUARD`.
- release: `S_GUARD` to `S_IDLE` at the next plain boundary.

Top module: `isr_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `irq_ack`, `stk_we`, `stk_re`, `pc_load`, `sp_ld`, `gie_clr` and `gie_set` are all 0.
- R2: A request is accepted only at a cycle where `insn_done`=1, `gie`=1 and `irq_pend` is non-zero. Pending requests with `gie`=0, or a boundary with no request, leave the block idle.
- R3: While `insn_done` stays 0 (a multi-cycle instruction), no request is accepted, whatever `gie` and `irq_pend` hold.
- R4: In the cycle after the accepting boundary, `irq_ack` is 1 for exactly one cycle. `irq_ack_idx` is the lowest set bit index of `irq_pend` at that boundary (bit 0 has the highest priority). `gie_clr` is 1 in the same cycle.
- R5: In entry cycle 1, `stk_we`=1, `stk_addr`=SP and `stk_wdata`=PC[7:0]. In entry cycle 2, `stk_we`=1, `stk_addr`=SP-1 and `stk_wdata`=PC[15:8]. SP and PC are `sp_cur` and `pc_cur` at the accepting boundary.
- R6: In entry cycle 3, `sp_ld`=1 with `sp_new`=SP-2.
- R7: In entry cycle 4, `pc_load`=1 with `pc_new`=VEC_BASE+index*VEC_STEP. `busy` is 1 in exactly the four entry cycles.
- R8: On a boundary with `reti_req`=1, four cycles follow. Cycle 1 reads SP+1 and cycle 2 reads SP+2 (`stk_re`=1, read data valid one cycle after the address). Cycle 3 has `sp_ld`=1 with `sp_new`=SP+2. Cycle 4 has `pc_load`=1 with `pc_new`={byte read at SP+1, byte read at SP+2} and `gie_set`=1.
- R9: After a return, the first boundary does not accept a pending request even with `gie`=1. The second boundary does accept it.
- R10: A boundary with `reti_req`=1 starts the return sequence, with no acknowledge, even when a request is pending and `gie`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | N_SRC | Pending request flags, bit 0 highest priority |
| gie | input | 1 | Global interrupt enable from the status register |
| insn_done | input | 1 | Current instruction completes this cycle |
| reti_req | input | 1 | The completing instruction is a return-from-interrupt |
| pc_cur | input | PC_W | Address of the next main-program instruction |
| sp_cur | input | SP_W | Current stack pointer |
| irq_ack | output | 1 | One-cycle acknowledge of the serviced source |
| irq_ack_idx | output | IDX_W | Index of the serviced source |
| busy | output | 1 | Sequence in progress, fetch stalled |
| gie_clr | output | 1 | Clear the global enable |
| gie_set | output | 1 | Set the global enable |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | PC_W | New program counter value |
| sp_ld | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | SP_W | New stack pointer value |
| stk_we | output | 1 | Stack memory write strobe |
| stk_re | output | 1 | Stack memory read strobe |
| stk_addr | output | SP_W | Stack memory byte address |
| stk_wdata | output | 8 | Stack memory write byte |
| stk_rdata | input | 8 | Stack memory read byte, valid one cycle after the address |

## Verification
The bench holds requests across a long multi-cycle instruction to catch a design that accepts mid-instruction. It also raises a request on the first boundary after a return, where a design without the one-instruction guard would acknowledge at once. Byte order and stack-pointer direction are checked by running a nested entry followed by two returns against a byte-wide memory model. A swapped byte or an off-by-one address would restore the wrong program counter. A return and a pending request are presented at the same boundary, which exposes a design that lets the request win and corrupts the return.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_PUSH_LO = 4'd1,
        S_PUSH_HI = 4'd2,
        S_ENT_SP  = 4'd3,
        S_ENT_VEC = 4'd4,
        S_POP_HI  = 4'd5,
        S_POP_LO  = 4'd6,
        S_RET_SP  = 4'd7,
        S_RET_PC  = 4'd8,
        S_GUARD   = 4'd9
    } seq_state_t;

    localparam int unsigned STK_BYTE_W = 8;

endpackage

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Each stage passes the winning index down the chain; lower bits override.
    logic [IDX_W-1:0] stage_idx [N_SRC:0];
    logic [N_SRC:0]   stage_hit;

    assign stage_idx[N_SRC] = '0;
    assign stage_hit[N_SRC] = 1'b0;

    genvar g;
    generate
        for (g = N_SRC - 1; g >= 0; g--) begin : g_stage
            assign stage_hit[g] = stage_hit[g+1] | req[g];
            assign stage_idx[g] = req[g] ? IDX_W'(g) : stage_idx[g+1];
        end
    endgenerate

    assign any = stage_hit[0];
    assign idx = stage_idx[0];

endmodule

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
    import isr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       insn_done,
    input  logic       reti_req,
    input  logic       take_irq,
    output seq_state_t st,
    output logic       start_ent,
    output logic       start_ret
);

    seq_state_t st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (insn_done) begin
                    if (reti_req)      st_nx = S_POP_HI;
                    else if (take_irq) st_nx = S_PUSH_LO;
                end
            end
            S_PUSH_LO: st_nx = S_PUSH_HI;
            S_PUSH_HI: st_nx = S_ENT_SP;
            S_ENT_SP:  st_nx = S_ENT_VEC;
            S_ENT_VEC: st_nx = S_IDLE;
            S_POP_HI:  st_nx = S_POP_LO;
            S_POP_LO:  st_nx = S_RET_SP;
            S_RET_SP:  st_nx = S_RET_PC;
            S_RET_PC:  st_nx = S_GUARD;
            S_GUARD: begin
                if (insn_done) st_nx = reti_req ? S_POP_HI : S_IDLE;
            end
            default:   st_nx = S_IDLE;
        endcase
    end

    assign start_ent = (st == S_IDLE) && (st_nx == S_PUSH_LO);
    assign start_ret = (st_nx == S_POP_HI);

    // R3: no progress out of idle without an instruction boundary
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !insn_done) |=> (st == S_IDLE));

    // R9: the guard state never hands over directly to an entry
    a_r9_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_GUARD) |=> (st != S_PUSH_LO));

    // R10: a return at the boundary wins over any pending request
    a_r10_reti_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && insn_done && reti_req) |=> (st == S_POP_HI));

endmodule

// File: rtl/isr_seq_dp.sv
module isr_seq_dp
    import isr_seq_pkg::*;
#(
    parameter int unsigned PC_W      = 16,
    parameter int unsigned SP_W      = 16,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned VEC_BASE  = 1,
    parameter int unsigned VEC_STEP  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_t            st,
    input  logic                  start_ent,
    input  logic                  start_ret,
    input  logic [IDX_W-1:0]      win_idx,
    input  logic [PC_W-1:0]       pc_cur,
    input  logic [SP_W-1:0]       sp_cur,
    input  logic [STK_BYTE_W-1:0] stk_rdata,
    output logic                  irq_ack,
    output logic [IDX_W-1:0]      irq_ack_idx,
    output logic                  busy,
    output logic                  gie_clr,
    output logic                  gie_set,
    output logic                  pc_load,
    output logic [PC_W-1:0]       pc_new,
    output logic                  sp_ld,
    output logic [SP_W-1:0]       sp_new,
    output logic                  stk_we,
    output logic                  stk_re,
    output logic [SP_W-1:0]       stk_addr,
    output logic [STK_BYTE_W-1:0] stk_wdata
);

    localparam int unsigned RET_W = 2 * STK_BYTE_W;

    logic [RET_W-1:0]      ret_q;
    logic [SP_W-1:0]       sp_q;
    logic [IDX_W-1:0]      idx_q;
    logic [STK_BYTE_W-1:0] hi_q;
    logic [STK_BYTE_W-1:0] lo_q;
    logic [PC_W-1:0]       vec_addr;

    // Snapshot the boundary context, and collect the popped bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
            sp_q  <= '0;
            idx_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (start_ent) begin
                ret_q <= RET_W'(pc_cur);
                idx_q <= win_idx;
            end
            if (start_ent || start_ret) sp_q <= sp_cur;
            if (st == S_POP_LO) hi_q <= stk_rdata;
            if (st == S_RET_SP) lo_q <= stk_rdata;
        end
    end

    assign vec_addr = PC_W'(VEC_BASE) + PC_W'(idx_q) * PC_W'(VEC_STEP);

    always_comb begin
        irq_ack     = 1'b0;
        irq_ack_idx = idx_q;
        busy        = 1'b1;
        gie_clr     = 1'b0;
        gie_set     = 1'b0;
        pc_load     = 1'b0;
        pc_new      = '0;
        sp_ld       = 1'b0;
        sp_new      = '0;
        stk_we      = 1'b0;
        stk_re      = 1'b0;
        stk_addr    = '0;
        stk_wdata   = '0;
        unique case (st)
            S_IDLE, S_GUARD: busy = 1'b0;
            S_PUSH_LO: begin
                irq_ack   = 1'b1;
                gie_clr   = 1'b1;
                stk_we    = 1'b1;
                stk_addr  = sp_q;
                stk_wdata = ret_q[STK_BYTE_W-1:0];
            end
            S_PUSH_HI: begin
                stk_we    = 1'b1;
                stk_addr  = sp_q - SP_W'(1);
                stk_wdata = ret_q[RET_W-1:STK_BYTE_W];
            end
            S_ENT_SP: begin
                sp_ld  = 1'b1;
                sp_new = sp_q - SP_W'(2);
            end
            S_ENT_VEC: begin
                pc_load = 1'b1;
                pc_new  = vec_addr;
            end
            S_POP_HI: begin
                stk_re   = 1'b1;
                stk_addr = sp_q + SP_W'(1);
            end
            S_POP_LO: begin
                stk_re   = 1'b1;
                stk_addr = sp_q + SP_W'(2);
            end
            S_RET_SP: begin
                sp_ld  = 1'b1;
                sp_new = sp_q + SP_W'(2);
            end
            S_RET_PC: begin
                pc_load = 1'b1;
                gie_set = 1'b1;
                pc_new  = PC_W'({hi_q, lo_q});
            end
            default: busy = 1'b0;
        endcase
    end

    // R4: the acknowledge is a single-cycle pulse
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R5: the second push lands one byte below the first
    a_r5_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_we) |=> (stk_we && stk_addr == $past(stk_addr) - SP_W'(1)));

    // R8: the second pop reads one byte above the first
    a_r8_pop_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_re) |=> (stk_re && stk_addr == $past(stk_addr) + SP_W'(1)));

endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer
    import isr_seq_pkg::*;
#(
    parameter int unsigned N_SRC    = 8,
    parameter int unsigned PC_W     = 16,
    parameter int unsigned SP_W     = 16,
    parameter int unsigned VEC_BASE = 1,
    parameter int unsigned VEC_STEP = 1,
    localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_pend,
    input  logic             gie,
    input  logic             insn_done,
    input  logic             reti_req,
    input  logic [PC_W-1:0]  pc_cur,
    input  logic [SP_W-1:0]  sp_cur,
    output logic             irq_ack,
    output logic [IDX_W-1:0] irq_ack_idx,
    output logic             busy,
    output logic             gie_clr,
    output logic             gie_set,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_new,
    output logic             sp_ld,
    output logic [SP_W-1:0]  sp_new,
    output logic             stk_we,
    output logic             stk_re,
    output logic [SP_W-1:0]  stk_addr,
    output logic [7:0]       stk_wdata,
    input  logic [7:0]       stk_rdata
);

    logic             req_any;
    logic [IDX_W-1:0] req_idx;
    seq_state_t       st;
    logic             start_ent;
    logic             start_ret;

    isr_prio_pick #(.N_SRC(N_SRC)) u_pick (
        .req (irq_pend),
        .any (req_any),
        .idx (req_idx)
    );

    isr_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .reti_req  (reti_req),
        .take_irq  (gie & req_any),
        .st        (st),
        .start_ent (start_ent),
        .start_ret (start_ret)
    );

    isr_seq_dp #(
        .PC_W     (PC_W),
        .SP_W     (SP_W),
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .st          (st),
        .start_ent   (start_ent),
        .start_ret   (start_ret),
        .win_idx     (req_idx),
        .pc_cur      (pc_cur),
        .sp_cur      (sp_cur),
        .stk_rdata   (stk_rdata),
        .irq_ack     (irq_ack),
        .irq_ack_idx (irq_ack_idx),
        .busy        (busy),
        .gie_clr     (gie_clr),
        .gie_set     (gie_set),
        .pc_load     (pc_load),
        .pc_new      (pc_new),
        .sp_ld       (sp_ld),
        .sp_new      (sp_new),
        .stk_we      (stk_we),
        .stk_re      (stk_re),
        .stk_addr    (stk_addr),
        .stk_wdata   (stk_wdata)
    );

    // R1: the sequence strobes never overlap
    a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_we, stk_re, pc_load, sp_ld}));

    // R2: an acknowledge follows an enabled boundary with a pending request
    a_r2_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(gie && insn_done && (|irq_pend)));

    // R7: the vector is loaded three cycles after the acknowledge
    a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ##3 pc_load);

endmodule

// File: tb/tb_isr_sequencer.sv
module tb_isr_sequencer;

    localparam int unsigned N_SRC    = 8;
    localparam int unsigned PC_W     = 16;
    localparam int unsigned SP_W     = 16;
    localparam int unsigned VEC_BASE = 2;
    localparam int unsigned VEC_STEP = 2;
    localparam int unsigned IDX_W    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] irq_pend = '0;
    logic             insn_done = 1'b0;
    logic             reti_req = 1'b0;
    logic [PC_W-1:0]  pc_cur = '0;
    logic             irq_ack, busy, gie_clr, gie_set, pc_load, sp_ld, stk_we, stk_re;
    logic [IDX_W-1:0] irq_ack_idx;
    logic [PC_W-1:0]  pc_new;
    logic [SP_W-1:0]  sp_new, stk_addr;
    logic [7:0]       stk_wdata;
    logic [7:0]       rdata_m;

    // environment models: stack pointer, enable flag, byte memory
    logic [SP_W-1:0]  sp_m;
    logic             gie_m;
    logic             gie_on_req = 1'b0;
    logic [7:0]       mem [0:255];

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    isr_sequencer #(
        .N_SRC(N_SRC), .PC_W(PC_W), .SP_W(SP_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .gie(gie_m),
        .insn_done(insn_done), .reti_req(reti_req), .pc_cur(pc_cur),
        .sp_cur(sp_m), .irq_ack(irq_ack), .irq_ack_idx(irq_ack_idx),
        .busy(busy), .gie_clr(gie_clr), .gie_set(gie_set),
        .pc_load(pc_load), .pc_new(pc_new), .sp_ld(sp_ld), .sp_new(sp_new),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(rdata_m)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            sp_m  <= 16'h00F0;
            gie_m <= 1'b0;
        end else begin
            if (sp_ld) sp_m <= sp_new;
            if (gie_on_req)   gie_m <= 1'b1;
            else if (gie_clr) gie_m <= 1'b0;
            else if (gie_set) gie_m <= 1'b1;
        end
        if (stk_we) mem[stk_addr[7:0]] <= stk_wdata;
        rdata_m <= mem[stk_addr[7:0]];
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enable_gie();
        gie_on_req = 1'b1;
        tick();
        gie_on_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 ack", irq_ack, 0);
        check("R1 strobes", {stk_we, stk_re, pc_load, sp_ld}, 0);
        check("R1 gie strobes", {gie_clr, gie_set}, 0);
    endtask

    task automatic t_masked();
        irq_pend = 8'h04; insn_done = 1'b1;   // gie is 0 here
        tick();
        check("R2 masked busy", busy, 0);
        check("R2 masked ack", irq_ack, 0);
        irq_pend = 8'h00;
        enable_gie();
        tick();                               // boundary with nothing pending
        check("R2 empty busy", busy, 0);
        check("R2 empty ack", irq_ack, 0);
        insn_done = 1'b0;
    endtask

    task automatic t_multicycle();
        irq_pend = 8'h24; insn_done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R3 stall idle", {busy, irq_ack}, 0);
        end
    endtask

    task automatic t_entry(input logic [15:0] pc, input logic [7:0] pend, input int idx);
        logic [15:0] sp0;
        sp0 = sp_m;
        irq_pend = pend; pc_cur = pc; insn_done = 1'b1;
        tick();
        insn_done = 1'b0; irq_pend = '0;
        check("R4 ack", irq_ack, 1);
        check("R4 idx", irq_ack_idx, idx);
        check("R4 gie_clr", gie_clr, 1);
        check("R5 push lo", {stk_we, stk_addr, stk_wdata}, {1'b1, sp0, pc[7:0]});
        check("R7 busy c1", busy, 1);
        tick();
        check("R4 ack one cycle", irq_ack, 0);
        check("R5 push hi", {stk_we, stk_addr, stk_wdata}, {1'b1, sp0 - 16'd1, pc[15:8]});
        tick();
        check("R6 sp load", {sp_ld, sp_new}, {1'b1, sp0 - 16'd2});
        tick();
        check("R7 vector", {pc_load, pc_new}, {1'b1, 16'(VEC_BASE + idx * VEC_STEP)});
        check("R7 busy c4", busy, 1);
        tick();
        check("R7 busy end", busy, 0);
        check("R6 sp model", sp_m, sp0 - 16'd2);
        check("R4 gie cleared", gie_m, 0);
    endtask

    task automatic t_return(input logic [15:0] exp_pc);
        logic [15:0] sp0;
        sp0 = sp_m;
        reti_req = 1'b1; insn_done = 1'b1;
        tick();
        reti_req = 1'b0; insn_done = 1'b0;
        check("R10 no ack on return", irq_ack, 0);
        check("R8 pop hi", {stk_re, stk_addr}, {1'b1, sp0 + 16'd1});
        tick();
        check("R8 pop lo", {stk_re, stk_addr}, {1'b1, sp0 + 16'd2});
        tick();
        check("R8 sp load", {sp_ld, sp_new}, {1'b1, sp0 + 16'd2});
        tick();
        check("R8 pc restore", {pc_load, pc_new, gie_set}, {1'b1, exp_pc, 1'b1});
        tick();
        check("R8 busy end", busy, 0);
        check("R8 sp model", sp_m, sp0 + 16'd2);
        check("R8 gie set", gie_m, 1);
    endtask

    task automatic t_guard();
        irq_pend = 8'h80; insn_done = 1'b1; pc_cur = 16'h0456;
        tick();
        check("R9 first boundary", {irq_ack, busy}, 0);
        tick();
        insn_done = 1'b0; irq_pend = '0;
        check("R9 second boundary ack", irq_ack, 1);
        check("R9 idx", irq_ack_idx, 7);
        check("R5 guard push lo", stk_wdata, 8'h56);
        tick(); tick(); tick();
        check("R7 guard vector", pc_new, 16'(VEC_BASE + 7 * VEC_STEP));
        tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_masked();
        t_multicycle();
        enable_gie();
        t_entry(16'h1234, 8'h24, 2);
        t_return(16'h1234);
        t_guard();                       // outer frame holds 0x0456
        enable_gie();
        t_entry(16'hBEEF, 8'h01, 0);     // nested frame
        enable_gie();
        irq_pend = 8'h10;                // R10: pending with gie=1 at reti
        t_return(16'hBEEF);
        irq_pend = '0;
        tick();
        t_return(16'h0456);
        summary();
        $finish;
    end

endmodule